// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a half-duplex SPI master that runs one flash-style command at a time. Software works through a byte-wide register window. It loads an opcode, places outgoing bytes in a shared byte FIFO, sets a transmit count and a receive count, picks one of four chip selects, and then writes a start bit. The engine lowers the chosen chip select and shifts out the opcode, then the counted transmit bytes. It then clocks in the counted receive bytes and stores them in the same FIFO, directly after the transmit data. A busy flag covers the whole command, so software polls it before it reads results or starts the next command.

The serial side uses SPI mode 0. SCLK idles low, data changes on the falling edge and is sampled on the rising edge, and bytes go MSB first. SCLK runs at the system clock divided by `2*HALF_DIV`.

Two register layouts are offered, selected by the `ALT_MAP` parameter. In the default layout the opcode, start, clear and busy bits share one 32-bit control word at offset 0x00. The word is little-endian across byte addresses 0x00..0x03. In the alternate layout the opcode, the start bit and the busy flag each sit in a separate byte or status word.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, busy reads 0, the opcode, transmit-count and receive-count registers read 0, all four `cs_n_o` lines are high, and `sclk_o` and `mosi_o` are low.
- R2: A write of 1 to the start bit (default map: byte 0x02 bit 0, which is control-word bit 16) sets busy, read at byte 0x03 bit 7 (control-word bit 31), from the next clock. Busy stays 1 until the chip select has been released, and it reads 0 only when all `cs_n_o` lines are high.
- R3: A command with transmit count N (byte 0x48) and receive count M (byte 0x4B) moves exactly N+M+1 bytes on the bus. The first byte is the opcode (byte 0x00), followed by FIFO bytes 0..N-1 in index order, each MSB first. SCLK idles low and the data is valid at its rising edge.
- R4: Received byte i is written to FIFO index N+i. The FIFO is read and written at byte address 0x80+index.
- R5: The bus is half duplex. `mosi_o` is 0 throughout the receive bytes, and FIFO bytes 0..N-1 still hold the transmit data after the command.
- R6: The chip-select byte at 0x1D selects line `cs_n_o[sel]` through its low 2 bits. Only that line goes low, and only during a command. The upper 6 bits are stored and read back unchanged.
- R7: The first rising SCLK edge comes 3*HALF_DIV clocks after the chip select falls, which is one full SCLK period of setup plus a low half-period. The chip select rises 2*HALF_DIV clocks after the final falling SCLK edge.
- R8: The FIFO-clear bit (byte 0x02 bit 4, control-word bit 20) reads back 0. Every start resets the FIFO pointer to index 0, so back-to-back commands each place received data from index N.
- R9: While busy, writes to the FIFO, the counts, the opcode and the chip-select byte are ignored, and a second start does not queue another command.
- R10: With `ALT_MAP=1`, the opcode is at 0x45, start is byte 0x47 bit 7, and busy is byte 0x4F bit 7 (status-word bit 31 at 0x4C). A write to byte 0x02 bit 0 then does not start a command, and the default-map engine ignores a write to 0x47.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe for the register window |
| addr_i | input | 8 | Byte address in the register window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| sclk_o | output | 1 | SPI serial clock, idles low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |
| cs_n_o | output | 4 | Active-low chip selects |

## Verification
The bench targets the corner cases where the counted phases meet. These are commands with no transmit bytes or no receive bytes, and a command that is only an opcode. A sequencer that miscounted would send one byte too many or too few, or would drive transmit data into the receive slots. The bench also checks where receive data lands after two commands in a row. A pointer that was not reset on start would place the second result at the wrong index. Writes and a second start issued mid-command must leave the FIFO, the counts and the chip select untouched. Finally, the chip-select setup and hold spacing is measured against exact clock counts, so an off-by-one in either wait phase shows up.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] A_CTRL_OPC = 8'h00;
  localparam logic [7:0] A_CTRL_B2  = 8'h02;
  localparam logic [7:0] A_CTRL_B3  = 8'h03;
  localparam logic [7:0] A_CSSEL    = 8'h1D;
  localparam logic [7:0] A_ALT_OPC  = 8'h45;
  localparam logic [7:0] A_ALT_TRIG = 8'h47;
  localparam logic [7:0] A_TXCNT    = 8'h48;
  localparam logic [7:0] A_RXCNT    = 8'h4B;
  localparam logic [7:0] A_ALT_STAT = 8'h4F;
  localparam logic [7:0] A_FIFO     = 8'h80;

  localparam int EXEC_BIT     = 0;  // word bit 16
  localparam int CLR_BIT      = 4;  // word bit 20
  localparam int ALT_TRIG_BIT = 7;
  localparam int BUSY_BIT     = 7;  // word bit 31

  localparam int NUM_CS = 4;
  localparam int CS_W   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} seq_st_e;
  typedef enum logic [1:0] {PH_OP, PH_TX, PH_RX} phase_e;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int IDX_W   = 6,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             busy_i,
  input  logic             seq_we_i,
  input  logic [IDX_W-1:0] seq_idx_i,
  input  logic [7:0]       seq_wdata_i,
  output logic [7:0]       rdata_o,
  output logic             start_o,
  output logic             clr_o,
  output logic [7:0]       opcode_o,
  output logic [7:0]       tx_cnt_o,
  output logic [7:0]       rx_cnt_o,
  output logic [CS_W-1:0]  cs_sel_o,
  output logic [7:0]       seq_rdata_o
);
  localparam logic [7:0] OPC_A  = ALT_MAP ? A_ALT_OPC  : A_CTRL_OPC;
  localparam logic [7:0] TRIG_A = ALT_MAP ? A_ALT_TRIG : A_CTRL_B2;
  localparam int         TRIG_B = ALT_MAP ? ALT_TRIG_BIT : EXEC_BIT;
  localparam logic [7:0] STAT_A = ALT_MAP ? A_ALT_STAT : A_CTRL_B3;
  localparam logic [8:0] FIFO_END = {1'b0, A_FIFO} + 9'(DEPTH);

  logic [7:0] opcode_q, tx_q, rx_q, cs_q;
  logic [7:0] fifo_q [DEPTH];
  logic       bus_ok, fifo_hit;
  logic [IDX_W-1:0] bus_idx;

  assign bus_ok   = wr_en_i && !busy_i;
  assign fifo_hit = (addr_i >= A_FIFO) && ({1'b0, addr_i} < FIFO_END);
  assign bus_idx  = addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_q <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      cs_q     <= '0;
      for (int i = 0; i < DEPTH; i++) fifo_q[i] <= '0;
    end else begin
      if (bus_ok) begin
        if (addr_i == OPC_A)   opcode_q <= wdata_i;
        if (addr_i == A_TXCNT) tx_q     <= wdata_i;
        if (addr_i == A_RXCNT) rx_q     <= wdata_i;
        if (addr_i == A_CSSEL) cs_q     <= wdata_i;
        if (fifo_hit)          fifo_q[bus_idx] <= wdata_i;
      end
      if (seq_we_i) fifo_q[seq_idx_i] <= seq_wdata_i;
    end
  end

  assign start_o = bus_ok && (addr_i == TRIG_A) && wdata_i[TRIG_B];
  assign clr_o   = bus_ok && (addr_i == A_CTRL_B2) && wdata_i[CLR_BIT];

  always_comb begin
    rdata_o = '0;
    if (addr_i == OPC_A)        rdata_o = opcode_q;
    else if (addr_i == STAT_A)  rdata_o = {busy_i, 7'b0};
    else if (addr_i == A_TXCNT) rdata_o = tx_q;
    else if (addr_i == A_RXCNT) rdata_o = rx_q;
    else if (addr_i == A_CSSEL) rdata_o = cs_q;
    else if (fifo_hit)          rdata_o = fifo_q[bus_idx];
  end

  assign opcode_o    = opcode_q;
  assign tx_cnt_o    = tx_q;
  assign rx_cnt_o    = rx_q;
  assign cs_sel_o    = cs_q[CS_W-1:0];
  assign seq_rdata_o = fifo_q[seq_idx_i];

  // R2
  trig_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_i);
  // R9
  opc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(opcode_q));
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(tx_q) && $stable(rx_q) && $stable(cs_q)));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int IDX_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic [7:0]       opcode_i,
  input  logic [7:0]       tx_cnt_i,
  input  logic [7:0]       rx_cnt_i,
  input  logic [7:0]       fifo_rdata_i,
  input  logic             miso_i,
  output logic [IDX_W-1:0] fifo_idx_o,
  output logic             fifo_we_o,
  output logic [7:0]       fifo_wdata_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  localparam int PER    = 2 * HALF_DIV;
  localparam int DIV_W  = $clog2(HALF_DIV + 1);
  localparam int WAIT_W = $clog2(PER + 1);

  seq_st_e          state_q;
  phase_e           phase_q;
  logic [7:0]       sh_q, rx_sh_q, rem_tx_q, rem_rx_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;
  logic [WAIT_W-1:0] wait_q;
  logic [IDX_W-1:0] ptr_q;
  logic             sclk_q;
  logic             half_end, wait_end;

  assign half_end = (div_q == DIV_W'(HALF_DIV - 1));
  assign wait_end = (wait_q == WAIT_W'(PER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_OP;
      sh_q     <= '0;
      rx_sh_q  <= '0;
      rem_tx_q <= '0;
      rem_rx_q <= '0;
      bit_q    <= '0;
      div_q    <= '0;
      wait_q   <= '0;
      ptr_q    <= '0;
      sclk_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (clr_i) ptr_q <= '0;
          if (start_i) begin
            state_q  <= ST_LEAD;
            sh_q     <= opcode_i;
            rem_tx_q <= tx_cnt_i;
            rem_rx_q <= rx_cnt_i;
            ptr_q    <= '0;
            phase_q  <= PH_OP;
            wait_q   <= '0;
          end
        end
        ST_LEAD: begin
          if (wait_end) begin
            state_q <= ST_SHIFT;
            div_q   <= '0;
            bit_q   <= 3'd7;
            sclk_q  <= 1'b0;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!half_end) begin
            div_q <= div_q + 1'b1;
          end else begin
            div_q <= '0;
            if (!sclk_q) begin
              sclk_q  <= 1'b1;
              rx_sh_q <= {rx_sh_q[6:0], miso_i};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q != 3'd0) begin
                bit_q <= bit_q - 1'b1;
                sh_q  <= {sh_q[6:0], 1'b0};
              end else begin
                bit_q <= 3'd7;
                if (phase_q != PH_RX && rem_tx_q != 8'd0) begin
                  phase_q  <= PH_TX;
                  sh_q     <= fifo_rdata_i;
                  ptr_q    <= ptr_q + 1'b1;
                  rem_tx_q <= rem_tx_q - 1'b1;
                end else if (rem_rx_q != 8'd0) begin
                  phase_q  <= PH_RX;
                  rem_rx_q <= rem_rx_q - 1'b1;
                  if (phase_q == PH_RX) ptr_q <= ptr_q + 1'b1;
                end else begin
                  state_q <= ST_TRAIL;
                  wait_q  <= '0;
                  if (phase_q == PH_RX) ptr_q <= ptr_q + 1'b1;
                end
              end
            end
          end
        end
        ST_TRAIL: begin
          if (wait_end) state_q <= ST_IDLE;
          else          wait_q  <= wait_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fifo_idx_o   = ptr_q;
  assign fifo_we_o    = (state_q == ST_SHIFT) && half_end && sclk_q &&
                        (bit_q == 3'd0) && (phase_q == PH_RX);
  assign fifo_wdata_o = rx_sh_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign sclk_o       = sclk_q;
  assign mosi_o       = (state_q == ST_SHIFT) && (phase_q != PH_RX) && sh_q[7];

  // R3
  sclk_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> busy_o);
  // R8
  start_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (fifo_idx_o == '0));
endmodule

// File: rtl/spi_cs_dec.sv
module spi_cs_dec
  import spi_cmd_pkg::*;
(
  input  logic            en_i,
  input  logic [CS_W-1:0] sel_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(en_i && (sel_i == CS_W'(g)));
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int FIFO_DEPTH = 64,
  parameter bit ALT_MAP    = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic [3:0] cs_n_o
);
  localparam int IDX_W = $clog2(FIFO_DEPTH);

  logic             start, clr, busy, seq_we;
  logic [7:0]       opcode, tx_cnt, rx_cnt, seq_wdata, seq_rdata;
  logic [IDX_W-1:0] seq_idx;
  logic [CS_W-1:0]  cs_sel;

  spi_cmd_regs #(.DEPTH(FIFO_DEPTH), .IDX_W(IDX_W), .ALT_MAP(ALT_MAP)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .busy_i(busy), .seq_we_i(seq_we), .seq_idx_i(seq_idx), .seq_wdata_i(seq_wdata),
    .rdata_o, .start_o(start), .clr_o(clr), .opcode_o(opcode),
    .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt), .cs_sel_o(cs_sel), .seq_rdata_o(seq_rdata)
  );

  spi_cmd_seq #(.HALF_DIV(HALF_DIV), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .clr_i(clr), .opcode_i(opcode),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .fifo_rdata_i(seq_rdata), .miso_i,
    .fifo_idx_o(seq_idx), .fifo_we_o(seq_we), .fifo_wdata_o(seq_wdata),
    .busy_o(busy), .sclk_o, .mosi_o
  );

  spi_cs_dec u_cs (.en_i(busy), .sel_i(cs_sel), .cs_n_o);

  // R6
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (cs_n_o == 4'hF));
  // R6
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R4
  rx_wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_we |-> busy);
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  localparam int HALF = 2;
  localparam int PER  = 2 * HALF;
  localparam int CLKNS = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, wr_en, miso;
  logic [7:0] addr, wdata, rdata, rdata_alt;
  logic       sclk, mosi, sclk_a, mosi_a;
  logic [3:0] cs_n, cs_n_a;

  spi_cmd_engine #(.HALF_DIV(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n));

  spi_cmd_engine #(.HALF_DIV(HALF), .ALT_MAP(1'b1)) dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_alt), .sclk_o(sclk_a), .mosi_o(mosi_a), .miso_i(1'b1), .cs_n_o(cs_n_a));

  int n_chk = 0, n_fail = 0;

  function automatic logic [7:0] resp_f(int k);
    return 8'((k * 37 + 5) & 255);
  endfunction
  function automatic logic resp_bit(int k, int b);
    logic [7:0] v;
    v = resp_f(k);
    return v[7 - b];
  endfunction
  function automatic logic [7:0] txp(int i);
    return 8'((i * 29 + 17) & 255);
  endfunction

  // device model
  logic [7:0] mbytes [64];
  int   mcount = 0, bitc = 0;
  logic [7:0] msh;
  time  t_csf, t_r1, t_lf, t_csr;
  logic [3:0] cs_seen;
  bit   first_r;
  wire  act = ~&cs_n;

  initial miso = 1'b0;
  always @(posedge act) begin
    mcount = 0; bitc = 0; t_csf = $time; cs_seen = cs_n; first_r = 1'b1;
    miso = resp_bit(0, 0);
  end
  always @(negedge act) t_csr = $time;
  always @(posedge sclk) begin
    if (first_r) begin t_r1 = $time; first_r = 1'b0; end
    msh = {msh[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      if (mcount < 64) mbytes[mcount] = msh;
      mcount++;
      bitc = 0;
    end
  end
  always @(negedge sclk) begin
    t_lf = $time;
    miso = resp_bit(mcount, bitc);
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit alt, output logic [7:0] d);
    @(negedge clk); addr = a; #1;
    d = alt ? rdata_alt : rdata;
  endtask

  task automatic wait_done(input bit alt);
    logic [7:0] d;
    int k;
    k = 0;
    do begin
      rd(alt ? 8'h4F : 8'h03, alt, d);
      k++;
    end while (d[7] && k < 5000);
    chk(!d[7], "R2 busy clears", d, 0);
    if (!alt) chk(cs_n == 4'hF, "R2 cs released when idle", cs_n, 4'hF);
  endtask

  task automatic start_cmd(input logic [7:0] opc, input int n, input int m, input int cs);
    logic [7:0] d;
    for (int i = 0; i < n; i++) wr(8'h80 + 8'(i), txp(i));
    wr(8'h48, 8'(n));
    wr(8'h4B, 8'(m));
    wr(8'h1D, 8'(cs));
    wr(8'h00, opc);
    wr(8'h02, 8'h01);
    rd(8'h03, 1'b0, d);
    chk(d[7], "R2 busy after start", d, 8'h80);
  endtask

  task automatic check_cmd(input logic [7:0] opc, input int n, input int m, input int cs);
    logic [7:0] d;
    chk(mcount == n + m + 1, "R3 byte count", mcount, n + m + 1);
    chk(mbytes[0] == opc, "R3 opcode first", mbytes[0], opc);
    for (int i = 0; i < n; i++)
      chk(mbytes[1+i] == txp(i), "R3 tx byte", mbytes[1+i], txp(i));
    for (int i = 0; i < m; i++)
      chk(mbytes[1+n+i] == 8'h00, "R5 mosi quiet in rx", mbytes[1+n+i], 0);
    for (int i = 0; i < m; i++) begin
      rd(8'h80 + 8'(n + i), 1'b0, d);
      chk(d == resp_f(1 + n + i), "R4 rx placement", d, resp_f(1 + n + i));
    end
    for (int i = 0; i < n; i++) begin
      rd(8'h80 + 8'(i), 1'b0, d);
      chk(d == txp(i), "R5 tx data kept", d, txp(i));
    end
    chk(cs_seen == ~(4'b1 << cs), "R6 selected line only", cs_seen, ~(4'b1 << cs));
    chk((t_r1 - t_csf) == time'(3 * HALF * CLKNS), "R7 cs setup", int'(t_r1 - t_csf), 3 * HALF * CLKNS);
    chk((t_csr - t_lf) == time'(PER * CLKNS), "R7 cs hold", int'(t_csr - t_lf), PER * CLKNS);
  endtask

  task automatic run_cmd(input logic [7:0] opc, input int n, input int m, input int cs);
    start_cmd(opc, n, m, cs);
    wait_done(1'b0);
    check_cmd(opc, n, m, cs);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(8'h03, 1'b0, d); chk(d == 0, "R1 busy", d, 0);
    rd(8'h00, 1'b0, d); chk(d == 0, "R1 opcode", d, 0);
    rd(8'h48, 1'b0, d); chk(d == 0, "R1 tx count", d, 0);
    rd(8'h4B, 1'b0, d); chk(d == 0, "R1 rx count", d, 0);
    chk(cs_n == 4'hF, "R1 cs high", cs_n, 4'hF);
    chk(!sclk && !mosi, "R1 sclk mosi low", {sclk, mosi}, 0);
    rd(8'h4F, 1'b1, d); chk(d == 0, "R1 alt busy", d, 0);
  endtask

  task automatic t_cs_reg;
    logic [7:0] d;
    wr(8'h1D, 8'hA6);
    rd(8'h1D, 1'b0, d);
    chk(d == 8'hA6, "R6 cs byte readback", d, 8'hA6);
    run_cmd(8'h05, 0, 1, 2);
  endtask

  task automatic t_ptr;
    logic [7:0] d;
    wr(8'h02, 8'h10);
    rd(8'h02, 1'b0, d);
    chk(d == 0, "R8 clear bit reads 0", d, 0);
    run_cmd(8'h03, 3, 2, 0);
    run_cmd(8'h3B, 1, 3, 2);
    rd(8'h81, 1'b0, d);
    chk(d == resp_f(2), "R8 pointer restarted", d, resp_f(2));
  endtask

  task automatic t_ignore;
    logic [7:0] d;
    start_cmd(8'h0B, 2, 4, 1);
    wr(8'h80, 8'h55);
    wr(8'h48, 8'h09);
    wr(8'h00, 8'h77);
    wr(8'h1D, 8'h03);
    wr(8'h02, 8'h01);
    wait_done(1'b0);
    check_cmd(8'h0B, 2, 4, 1);
    rd(8'h48, 1'b0, d); chk(d == 8'h02, "R9 tx count held", d, 2);
    rd(8'h00, 1'b0, d); chk(d == 8'h0B, "R9 opcode held", d, 8'h0B);
    rd(8'h1D, 1'b0, d); chk(d == 8'h01, "R9 cs held", d, 1);
    repeat (4) @(negedge clk);
    rd(8'h03, 1'b0, d); chk(d == 0, "R9 no queued start", d, 0);
  endtask

  task automatic t_alt;
    logic [7:0] d;
    wr(8'h80, 8'hC3);
    wr(8'h48, 8'h01);
    wr(8'h4B, 8'h02);
    wr(8'h45, 8'h5A);
    wr(8'h02, 8'h01);
    rd(8'h4F, 1'b1, d); chk(d[7] == 1'b0, "R10 alt ignores default start", d, 0);
    wait_done(1'b0);
    wr(8'h47, 8'h80);
    rd(8'h03, 1'b0, d); chk(d[7] == 1'b0, "R10 default ignores alt start", d, 0);
    rd(8'h4F, 1'b1, d); chk(d[7] == 1'b1, "R10 alt busy", d, 8'h80);
    wait_done(1'b1);
    rd(8'h81, 1'b1, d); chk(d == 8'hFF, "R10 alt rx0", d, 8'hFF);
    rd(8'h82, 1'b1, d); chk(d == 8'hFF, "R10 alt rx1", d, 8'hFF);
    rd(8'h80, 1'b1, d); chk(d == 8'hC3, "R10 alt tx kept", d, 8'hC3);
    rd(8'h45, 1'b1, d); chk(d == 8'h5A, "R10 alt opcode", d, 8'h5A);
  endtask

  initial begin
    #(200000 * CLKNS);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_cmd(8'h9F, 0, 3, 1);
    run_cmd(8'h03, 4, 5, 2);
    run_cmd(8'h02, 6, 0, 3);
    run_cmd(8'h06, 0, 0, 0);
    t_cs_reg();
    t_ptr();
    t_ignore();
    t_alt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule